// File: doc/BRIEF.md
# Return-Stack Program Counter Sequencer

This block owns the program counter of a small 32-bit processor core together with a private hardware stack of return addresses. Each time the core finishes an instruction it raises a one-cycle completion strobe and presents that instruction's class, operation code, end-of-routine flag, both relative offsets and the comparison result from the datapath. On that edge the block picks the address of the next instruction and updates its stack.

Subroutines end without a dedicated return operation. Any instruction whose least significant bit is set ends the current routine, and the next fetch comes from the most recently saved return address. The stack pointer always names the free slot just above the newest entry, so an empty stack reads zero. Misuse of the stack raises two sticky error flags. It never corrupts stored entries.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset clears the PC to 0, the stack pointer to 0, and both error flags to 0.
- R2: While `instr_done` is low, the PC, the stack pointer and both flags keep their values, whatever the other inputs carry.
- R3: When `instr_done` is high and no rule below applies, the PC advances by 4. This covers class 00 and class 11, every class 10 code other than 00100, code 00100 with `branch_taken` low, and class 01 codes other than 00000 and 00001.
- R4: Class 01 with code 00000 loads PC + sign-extended `jump_off`, counted in bytes. The stack is untouched.
- R5: Class 01 with code 00001 loads PC + sign-extended `jump_off`. It also stores the old PC + 4 at the slot the stack pointer names and then increments the stack pointer.
- R6: Class 10 with code 00100 and `branch_taken` high loads PC + sign-extended `branch_off`.
- R7: With `ins_stop` high and the stack not empty, the stack pointer decrements and the PC loads the entry at the new pointer. This wins over every class and code, so entries come back in last-in, first-out order.
- R8: A call made with 16 entries already stored (`sp` = 16) sets the sticky `stack_ovf` flag. It stores nothing and leaves `sp` at 16, but the jump still happens.
- R9: A stop made with `sp` = 0 sets the sticky `stack_udf` flag. It leaves `sp` at 0 and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_done | input | 1 | Instruction-complete strobe |
| ins_kind | input | 2 | Instruction class: 00 register, 01 jump, 10 immediate, 11 shift |
| ins_func | input | 5 | Operation code within the class |
| ins_stop | input | 1 | End-of-routine bit (instruction LSB) |
| jump_off | input | 24 | Signed byte offset for jump and call |
| branch_off | input | 14 | Signed byte offset for the equality branch |
| branch_taken | input | 1 | Datapath found both compared registers equal |
| pc | output | 32 | Program counter, address for instruction fetch |
| sp | output | 5 | Stack pointer, index of the free slot |
| stack_ovf | output | 1 | Sticky: a call found the stack full |
| stack_udf | output | 1 | Sticky: a stop found the stack empty |

## Verification
The bench uses the default 32-bit PC and a 16-entry stack. With these values a short run can fill every slot, try a seventeenth call, and then unwind all sixteen entries in reverse order before one more stop underflows. A second phase walks through all four classes, all 32 codes, both stop values and both branch outcomes, with pseudo-random offsets of both signs. This reaches every priority between return, call, jump, branch and the sequential step against an arithmetic model of the stack.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        KIND_REG = 2'b00,
        KIND_JMP = 2'b01,
        KIND_IMM = 2'b10,
        KIND_SHF = 2'b11
    } ins_kind_e;

    localparam logic [4:0] FN_JUMP = 5'b00000;
    localparam logic [4:0] FN_CALL = 5'b00001;
    localparam logic [4:0] FN_BEQ  = 5'b00100;

    localparam int unsigned JOFF_W = 24;
    localparam int unsigned BOFF_W = 14;
    localparam int unsigned STEP_BYTES = 4;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_BRANCH,
        FLOW_RETURN
    } flow_e;

    typedef struct packed {
        flow_e flow;
        logic  push;
        logic  pop;
    } flow_ctl_t;

    // Return on stop bit has priority over all other flows.
    function automatic flow_e classify(input logic [1:0] kind,
                                       input logic [4:0] fn,
                                       input logic       stop,
                                       input logic       taken);
        flow_e f;
        if (stop)
            f = FLOW_RETURN;
        else if (kind == KIND_JMP && fn == FN_JUMP)
            f = FLOW_JUMP;
        else if (kind == KIND_JMP && fn == FN_CALL)
            f = FLOW_CALL;
        else if (kind == KIND_IMM && fn == FN_BEQ && taken)
            f = FLOW_BRANCH;
        else
            f = FLOW_SEQ;
        return f;
    endfunction

endpackage

// File: rtl/npc_flow_decode.sv
module npc_flow_decode
    import npc_pkg::*;
(
    input  logic       strobe,
    input  logic [1:0] kind,
    input  logic [4:0] fn,
    input  logic       stop,
    input  logic       taken,
    output flow_ctl_t  ctl
);

    always_comb begin
        ctl.flow = classify(kind, fn, stop, taken);
        ctl.push = strobe && (ctl.flow == FLOW_CALL);
        ctl.pop  = strobe && (ctl.flow == FLOW_RETURN);
    end

endmodule

// File: rtl/npc_ret_stack.sv
module npc_ret_stack #(
    parameter  int unsigned W     = 32,
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SP_W  = IDX_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    push_addr,
    output logic [W-1:0]    top_addr,
    output logic [SP_W-1:0] sp,
    output logic            empty,
    output logic            full,
    output logic            ovf,
    output logic            udf
);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign empty    = (sp == '0);
    assign full     = (sp == SP_W'(DEPTH));
    assign rd_idx   = IDX_W'(sp - 1'b1);
    assign wr_idx   = sp[IDX_W-1:0];
    assign top_addr = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      sp  <= sp + 1'b1;
            end
            if (pop) begin
                if (empty) udf <= 1'b1;
                else       sp  <= sp - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_idx] <= push_addr;
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        push && !full |=> sp == $past(sp) + 1'b1);                   // R5
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        pop && !empty |=> sp == $past(sp) - 1'b1);                   // R7
    AST_SP_BOUND: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(DEPTH));                                         // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);                                                // R8
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        push && full |=> sp == $past(sp) && ovf);                    // R8
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        udf |=> udf);                                                // R9
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        pop && empty |=> sp == '0 && udf);                           // R9

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  flow_e                  flow,
    input  logic [PC_W-1:0]        pc,
    input  logic [JOFF_W-1:0]      jump_off,
    input  logic [BOFF_W-1:0]      branch_off,
    input  logic [PC_W-1:0]        top_addr,
    input  logic                   empty,
    output logic [PC_W-1:0]        seq_pc,
    output logic [PC_W-1:0]        nxt_pc
);

    logic [PC_W-1:0] jump_ext;
    logic [PC_W-1:0] br_ext;

    assign jump_ext = {{(PC_W-JOFF_W){jump_off[JOFF_W-1]}}, jump_off};
    assign br_ext   = {{(PC_W-BOFF_W){branch_off[BOFF_W-1]}}, branch_off};
    assign seq_pc   = pc + PC_W'(STEP_BYTES);

    always_comb begin
        unique case (flow)
            FLOW_JUMP,
            FLOW_CALL:   nxt_pc = pc + jump_ext;
            FLOW_BRANCH: nxt_pc = pc + br_ext;
            FLOW_RETURN: nxt_pc = empty ? seq_pc : top_addr;
            default:     nxt_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter  int unsigned PC_W      = 32,
    parameter  int unsigned STK_DEPTH = 16,
    localparam int unsigned SP_W      = $clog2(STK_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_done,
    input  logic [1:0]          ins_kind,
    input  logic [4:0]          ins_func,
    input  logic                ins_stop,
    input  logic [23:0]         jump_off,
    input  logic [13:0]         branch_off,
    input  logic                branch_taken,
    output logic [PC_W-1:0]     pc,
    output logic [SP_W-1:0]     sp,
    output logic                stack_ovf,
    output logic                stack_udf
);

    flow_ctl_t       ctl;
    logic [PC_W-1:0] top_addr;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] nxt_pc;
    logic            empty;
    logic            full;

    npc_flow_decode i_decode (
        .strobe (instr_done),
        .kind   (ins_kind),
        .fn     (ins_func),
        .stop   (ins_stop),
        .taken  (branch_taken),
        .ctl    (ctl)
    );

    npc_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) i_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .pop       (ctl.pop),
        .push_addr (seq_pc),
        .top_addr  (top_addr),
        .sp        (sp),
        .empty     (empty),
        .full      (full),
        .ovf       (stack_ovf),
        .udf       (stack_udf)
    );

    npc_target #(.PC_W(PC_W)) i_target (
        .flow       (ctl.flow),
        .pc         (pc),
        .jump_off   (jump_off),
        .branch_off (branch_off),
        .top_addr   (top_addr),
        .empty      (empty),
        .seq_pc     (seq_pc),
        .nxt_pc     (nxt_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)             pc <= '0;
        else if (instr_done) pc <= nxt_pc;
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_done |=> $stable(pc) && $stable(sp));                 // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        instr_done && !ins_stop && ins_kind == KIND_REG
        |=> pc == $past(pc) + PC_W'(STEP_BYTES));                    // R3
    AST_JUMP_NO_STACK: assert property (@(posedge clk) disable iff (rst)
        instr_done && !ins_stop && ins_kind == KIND_JMP && ins_func == FN_JUMP
        |=> $stable(sp));                                            // R4
    AST_STOP_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        instr_done && ins_stop |=> sp <= $past(sp));                 // R7

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_done = 1'b0;
    logic [1:0]  ins_kind = 2'b00;
    logic [4:0]  ins_func = 5'b0;
    logic        ins_stop = 1'b0;
    logic [23:0] jump_off = 24'b0;
    logic [13:0] branch_off = 14'b0;
    logic        branch_taken = 1'b0;
    logic [31:0] pc;
    logic [4:0]  sp;
    logic        stack_ovf;
    logic        stack_udf;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_pc;
    int          m_sp;
    logic        m_ovf, m_udf;
    logic [31:0] m_stk [16];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst(rst), .instr_done(instr_done),
        .ins_kind(ins_kind), .ins_func(ins_func), .ins_stop(ins_stop),
        .jump_off(jump_off), .branch_off(branch_off),
        .branch_taken(branch_taken),
        .pc(pc), .sp(sp), .stack_ovf(stack_ovf), .stack_udf(stack_udf)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "pc", pc, m_pc);
        check(req, "sp", 32'(sp), 32'(m_sp));
        check(req, "ovf", 32'(stack_ovf), 32'(m_ovf));
        check(req, "udf", 32'(stack_udf), 32'(m_udf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_sp = 0; m_ovf = 0; m_udf = 0;
        check_all("R1");
    endtask

    task automatic step(input logic [1:0] k, input logic [4:0] f, input logic s,
                        input logic [23:0] j, input logic [13:0] b, input logic t);
        string req;
        logic [31:0] np;
        logic [31:0] jx;
        logic [31:0] bx;
        jx = {{8{j[23]}}, j};
        bx = {{18{b[13]}}, b};
        if (s) begin
            if (m_sp == 0) begin
                m_udf = 1'b1; np = m_pc + 4; req = "R9";
            end else begin
                m_sp--; np = m_stk[m_sp]; req = "R7";
            end
        end else if (k == 2'b01 && f == 5'b00000) begin
            np = m_pc + jx; req = "R4";
        end else if (k == 2'b01 && f == 5'b00001) begin
            np = m_pc + jx; req = "R5";
            if (m_sp == 16) begin
                m_ovf = 1'b1; req = "R8";
            end else begin
                m_stk[m_sp] = m_pc + 4; m_sp++;
            end
        end else if (k == 2'b10 && f == 5'b00100 && t) begin
            np = m_pc + bx; req = "R6";
        end else begin
            np = m_pc + 4; req = "R3";
        end
        ins_kind = k; ins_func = f; ins_stop = s;
        jump_off = j; branch_off = b; branch_taken = t;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        m_pc = np;
        check_all(req);
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // R2: strobe low, a call and a stop presented have no effect
        ins_kind = 2'b01; ins_func = 5'b00001; jump_off = 24'h000100;
        @(negedge clk);
        check_all("R2");
        ins_stop = 1'b1;
        @(negedge clk);
        check_all("R2");
        ins_stop = 1'b0;

        // R9: stop on an empty stack
        step(2'b00, 5'b00000, 1'b1, 24'h0, 14'h0, 1'b0);
        step(2'b11, 5'b00011, 1'b0, 24'h0, 14'h0, 1'b0);

        // R5, R8, R7: fill, overflow, then unwind in LIFO order
        do_reset();
        for (int n = 0; n < 16; n++)
            step(2'b01, 5'b00001, 1'b0, 24'(n * 64 + 8), 14'h0, 1'b0);
        step(2'b01, 5'b00001, 1'b0, 24'hFFFF00, 14'h0, 1'b0);
        step(2'b01, 5'b00001, 1'b0, 24'h000040, 14'h0, 1'b0);
        for (int n = 0; n < 16; n++)
            step(2'(n % 4), 5'(n), 1'b1, 24'h0, 14'h0, 1'b0);
        step(2'b10, 5'b00100, 1'b1, 24'h0, 14'h10, 1'b1);

        // R4, R6 with negative offsets
        do_reset();
        step(2'b01, 5'b00000, 1'b0, 24'h001000, 14'h0, 1'b0);
        step(2'b01, 5'b00000, 1'b0, 24'hFFFFF0, 14'h0, 1'b0);
        step(2'b10, 5'b00100, 1'b0, 24'h0, 14'h3FF8, 1'b1);
        step(2'b10, 5'b00100, 1'b0, 24'h0, 14'h0200, 1'b0);

        // Sweep over class, code, stop and branch outcome
        do_reset();
        for (int k = 0; k < 4; k++)
            for (int f = 0; f < 32; f++)
                for (int s = 0; s < 2; s++)
                    for (int t = 0; t < 2; t++) begin
                        logic [31:0] r;
                        r = rnd();
                        step(2'(k), 5'(f), 1'(s), r[23:0], r[31:18], 1'(t));
                    end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule